// File: doc/BRIEF.md
# Banked Matrix Memory Address Sequencer

This block drives the write side of a set of lane memories that hold square matrices spread across parallel arithmetic lanes. There are `2^LANES_LOG2` lanes, and each lane owns one A bank and one B bank. After a start strobe, the block walks a stream of matrix elements that arrive one per clock in row-major order. For each element it produces one bank write address and one set of bank write enables. It also picks the data source that each bank stores.

Three layouts are supported:
- **Keep** places the stream exactly as it arrives.
- **Flip** stores every element at the slot its transposed partner would occupy. This aligns a matrix for element-wise addition with a matrix kept in the other order, without a crossbar between lanes.
- **Spread** copies a length-n vector whole into every B bank, ready for an outer product.

Each read port can be forced to zero in place of stored data. A host port loads constants while the sequencer is idle.

Top module: `mat_bank_sequencer`

## Requirements
- R1: After reset the block is idle. busy, done and cfg_err are 0, and with host_we low every bank write enable is 0.
- R2: Layout keep (layout=0) places element e (row-major, e = row*n + col) in lane `e mod L`, at address `(base + e/L) mod 2^AW`. Here L is the lane count.
- R3: Layout flip (layout=1) places element (row, col) as if it were element `col*n + row` of layout keep, using the same lane and address formula.
- R4: Layout spread (layout=2) takes n elements. Element c is written to address `base + c` of every B bank at once, whatever tgt_b says.
- R5: An accepted start gives exactly n*n cycles of writes (n for spread), with busy=1 and done=0. done is then high for exactly one cycle, and the block returns to idle on the next cycle.
- R6: A start is refused, and sets cfg_err, when any of these holds: mat_n is not a power of two, mat_n is below L, mat_n is above `2^NMAX_LOG2`, layout is 3, or src is 0 or above 4. A refused start writes nothing and leaves busy at 0. The next accepted start clears cfg_err.
- R7: A host write (host_we) is granted only while idle. It then writes host_data to bank host_lane of set B if host_b=1, else set A, at host_addr. A host write made while busy is dropped.
- R8: The source code on src picks what sequenced writes store: 1 stores that lane's add_res slice, 2 stores that lane's mul_res slice, 3 stores tree_res, and 4 stores inv_res into A banks and sadd_res into B banks. tgt_b=1 writes the B set and tgt_b=0 writes the A set.
- R9: When zero_a[k] or zero_b[k] is 1, read port k of that set shows zero. The other ports keep showing stored data at rd_addr.
- R10: Configuration inputs are captured at the accepted start. Changing them, or pulsing start again during a run, does not alter that run.
- R11: Outside spread mode, at most one bank per set is write-enabled in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start strobe for a matrix write-back |
| layout | input | 2 | 0 keep, 1 flip, 2 spread |
| src | input | 3 | Sequenced write source code |
| tgt_b | input | 1 | 1 writes B set, 0 writes A set |
| base_addr | input | AW | Base address of the matrix in each bank |
| mat_n | input | NMAX_LOG2+1 | Matrix dimension n |
| add_res | input | L*DW | Per-lane adder results |
| mul_res | input | L*DW | Per-lane multiplier results |
| tree_res | input | DW | Reduced tree output |
| inv_res | input | DW | Inverter result (A banks) |
| sadd_res | input | DW | Scalar adder result (B banks) |
| host_we | input | 1 | Host write request |
| host_b | input | 1 | Host targets B set |
| host_lane | input | LANES_LOG2 | Host bank index |
| host_addr | input | AW | Host write address |
| host_data | input | DW | Host write data |
| rd_addr | input | AW | Common read address |
| zero_a | input | L | Force-zero per A read port |
| zero_b | input | L | Force-zero per B read port |
| rd_a | output | L*DW | A bank read data |
| rd_b | output | L*DW | B bank read data |
| wr_en_a | output | L | A bank write enables |
| wr_en_b | output | L | B bank write enables |
| wr_addr | output | AW | Write address presented to the banks |
| wsel | output | 3 | Granted write source code |
| host_gnt | output | 1 | Host write granted this cycle |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last start was refused |

## Verification
A row or column counter that steps wrongly moves elements to the wrong lane or address. That shows as a mismatched word the first time the bank is read back after the run. A wrong wrap bound shows at once as a shifted done pulse, because the pulse must follow exactly n*n write cycles. Stale configuration latches, or a host grant while busy, corrupt a word that the read ports expose right after the run. A flaw in the config check shows one cycle after the strobe as a wrong busy or cfg_err level.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [1:0] {
        LAYOUT_KEEP   = 2'd0,
        LAYOUT_FLIP   = 2'd1,
        LAYOUT_SPREAD = 2'd2
    } layout_e;

    typedef enum logic [2:0] {
        WSRC_HOST = 3'd0,
        WSRC_ADD  = 3'd1,
        WSRC_MUL  = 3'd2,
        WSRC_TREE = 3'd3,
        WSRC_AUX  = 3'd4
    } wsrc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } st_e;
endpackage

// File: rtl/mbs_cfg_check.sv
module mbs_cfg_check #(
    parameter int LANES_LOG2 = 2,
    parameter int NMAX_LOG2  = 3,
    parameter int NW         = NMAX_LOG2 + 1,
    parameter int LW         = 2
) (
    input  logic [NW-1:0] n_in,
    input  logic [1:0]    layout,
    input  logic [2:0]    src,
    output logic          ok,
    output logic [LW-1:0] nlog
);
    localparam int LANES = 1 << LANES_LOG2;
    localparam int NMAX  = 1 << NMAX_LOG2;

    logic pow2, range_ok, mode_ok, src_ok;

    always_comb begin
        nlog = '0;
        for (int b = 0; b < NW; b++) begin
            if (n_in[b]) nlog = LW'(b);
        end
        pow2     = (n_in != '0) && ((n_in & (n_in - 1'b1)) == '0);
        range_ok = (n_in >= NW'(LANES)) && (n_in <= NW'(NMAX));
        mode_ok  = (layout != 2'd3);
        src_ok   = (src != 3'd0) && (src <= 3'd4);
        ok       = pow2 && range_ok && mode_ok && src_ok;
    end
endmodule

// File: rtl/mbs_walker.sv
module mbs_walker
    import mbs_pkg::*;
#(
    parameter int LANES_LOG2 = 2,
    parameter int NMAX_LOG2  = 3,
    parameter int LW         = 2,
    parameter int OW         = 2 * NMAX_LOG2 - LANES_LOG2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic [LW-1:0]         nlog,
    input  logic [1:0]            layout,
    output logic [LANES_LOG2-1:0] lane,
    output logic [OW-1:0]         offset,
    output logic                  last,
    output logic                  spread
);
    localparam int IW = 2 * NMAX_LOG2;

    logic [NMAX_LOG2-1:0] row_q, col_q, mask;
    logic [LW-1:0]        nlog_q;
    layout_e              lay_q;
    logic [IW-1:0]        rw, cw, idx;

    assign mask = ~({NMAX_LOG2{1'b1}} << nlog_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            nlog_q <= '0;
            lay_q  <= LAYOUT_KEEP;
        end else if (load) begin
            row_q  <= '0;
            col_q  <= '0;
            nlog_q <= nlog;
            lay_q  <= layout_e'(layout);
        end else if (step) begin
            if (col_q == mask) begin
                col_q <= '0;
                row_q <= row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    always_comb begin
        rw = IW'(row_q);
        cw = IW'(col_q);
        unique case (lay_q)
            LAYOUT_FLIP:   idx = (cw << nlog_q) | rw;
            LAYOUT_SPREAD: idx = cw << LANES_LOG2;
            default:       idx = (rw << nlog_q) | cw;
        endcase
        lane   = idx[LANES_LOG2-1:0];
        offset = idx[IW-1:LANES_LOG2];
        spread = (lay_q == LAYOUT_SPREAD);
        last   = spread ? (col_q == mask) : ((col_q == mask) && (row_q == mask));
    end
endmodule

// File: rtl/mbs_bank.sv
module mbs_bank #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    input  logic          zero,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [1 << AW];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = zero ? '0 : mem[raddr];
endmodule

// File: rtl/mat_bank_sequencer.sv
module mat_bank_sequencer
    import mbs_pkg::*;
#(
    parameter int LANES_LOG2 = 2,
    parameter int NMAX_LOG2  = 3,
    parameter int DW         = 16,
    parameter int AW         = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [1:0]                    layout,
    input  logic [2:0]                    src,
    input  logic                          tgt_b,
    input  logic [AW-1:0]                 base_addr,
    input  logic [NMAX_LOG2:0]            mat_n,
    input  logic [(1<<LANES_LOG2)*DW-1:0] add_res,
    input  logic [(1<<LANES_LOG2)*DW-1:0] mul_res,
    input  logic [DW-1:0]                 tree_res,
    input  logic [DW-1:0]                 inv_res,
    input  logic [DW-1:0]                 sadd_res,
    input  logic                          host_we,
    input  logic                          host_b,
    input  logic [LANES_LOG2-1:0]         host_lane,
    input  logic [AW-1:0]                 host_addr,
    input  logic [DW-1:0]                 host_data,
    input  logic [AW-1:0]                 rd_addr,
    input  logic [(1<<LANES_LOG2)-1:0]    zero_a,
    input  logic [(1<<LANES_LOG2)-1:0]    zero_b,
    output logic [(1<<LANES_LOG2)*DW-1:0] rd_a,
    output logic [(1<<LANES_LOG2)*DW-1:0] rd_b,
    output logic [(1<<LANES_LOG2)-1:0]    wr_en_a,
    output logic [(1<<LANES_LOG2)-1:0]    wr_en_b,
    output logic [AW-1:0]                 wr_addr,
    output logic [2:0]                    wsel,
    output logic                          host_gnt,
    output logic                          busy,
    output logic                          done,
    output logic                          cfg_err
);
    localparam int LANES = 1 << LANES_LOG2;
    localparam int NW    = NMAX_LOG2 + 1;
    localparam int LW    = (NMAX_LOG2 < 2) ? 1 : $clog2(NMAX_LOG2 + 1);
    localparam int OW    = 2 * NMAX_LOG2 - LANES_LOG2;

    st_e                   state_q, state_d;
    logic                  cfg_ok, accept, load, running, last, spread;
    logic [LW-1:0]         nlog;
    logic [LANES_LOG2-1:0] lane;
    logic [OW-1:0]         offset;
    logic [AW-1:0]         base_q;
    wsrc_e                 src_q;
    logic                  tgt_q;

    mbs_cfg_check #(
        .LANES_LOG2(LANES_LOG2), .NMAX_LOG2(NMAX_LOG2), .NW(NW), .LW(LW)
    ) u_cfg (
        .n_in(mat_n), .layout(layout), .src(src), .ok(cfg_ok), .nlog(nlog)
    );

    mbs_walker #(
        .LANES_LOG2(LANES_LOG2), .NMAX_LOG2(NMAX_LOG2), .LW(LW), .OW(OW)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .step(running), .nlog(nlog),
        .layout(layout), .lane(lane), .offset(offset), .last(last), .spread(spread)
    );

    assign accept = start && (state_q == ST_IDLE);
    assign load   = accept && cfg_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_RUN;
            ST_RUN:  if (last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy    = 1'b1;
        running = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_RUN:  running = 1'b1;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            src_q   <= WSRC_TREE;
            tgt_q   <= 1'b0;
            cfg_err <= 1'b0;
        end else if (accept) begin
            cfg_err <= !cfg_ok;
            if (cfg_ok) begin
                base_q <= base_addr;
                src_q  <= wsrc_e'(src);
                tgt_q  <= tgt_b;
            end
        end
    end

    assign host_gnt = host_we && !busy;
    assign wr_addr  = host_gnt ? host_addr :
                      running  ? (base_q + AW'(offset)) : '0;
    assign wsel     = host_gnt ? 3'(WSRC_HOST) : running ? 3'(src_q) : 3'(WSRC_HOST);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic          hit, host_hit;
        logic [DW-1:0] shared, da, db;

        assign hit      = (lane == LANES_LOG2'(k));
        assign host_hit = host_gnt && (host_lane == LANES_LOG2'(k));

        assign wr_en_a[k] = (running && !spread && !tgt_q && hit) || (host_hit && !host_b);
        assign wr_en_b[k] = (running && (spread || (tgt_q && hit))) || (host_hit && host_b);

        always_comb begin
            case (src_q)
                WSRC_ADD: shared = add_res[k*DW +: DW];
                WSRC_MUL: shared = mul_res[k*DW +: DW];
                default:  shared = tree_res;
            endcase
            if (host_gnt) begin
                da = host_data;
                db = host_data;
            end else if (src_q == WSRC_AUX) begin
                da = inv_res;
                db = sadd_res;
            end else begin
                da = shared;
                db = shared;
            end
        end

        mbs_bank #(.DW(DW), .AW(AW)) u_bank_a (
            .clk(clk), .we(wr_en_a[k]), .waddr(wr_addr), .wdata(da),
            .raddr(rd_addr), .zero(zero_a[k]), .rdata(rd_a[k*DW +: DW])
        );

        mbs_bank #(.DW(DW), .AW(AW)) u_bank_b (
            .clk(clk), .we(wr_en_b[k]), .waddr(wr_addr), .wdata(db),
            .raddr(rd_addr), .zero(zero_b[k]), .rdata(rd_b[k*DW +: DW])
        );
    end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             host_we,
    input logic             host_gnt,
    input logic             cfg_err,
    input logic [LANES-1:0] wr_en_a,
    input logic [LANES-1:0] wr_en_b
);
    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !host_we) |-> (wr_en_a == '0 && wr_en_b == '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R7
    host_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_gnt);

    // R7
    host_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !busy) |-> host_gnt);

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !busy);

    // R11
    one_lane_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_a));
endmodule

bind mat_bank_sequencer mbs_checker #(.LANES(1 << LANES_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .host_we(host_we),
    .host_gnt(host_gnt), .cfg_err(cfg_err), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b)
);

// File: tb/mat_bank_sequencer_test.sv
module mat_bank_sequencer_test;
    localparam int LL = 2;
    localparam int L  = 4;
    localparam int DW = 16;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] layout = '0;
    logic [2:0] src = 3'd3;
    logic tgt_b = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [3:0] mat_n = 4'd4;
    logic [L*DW-1:0] add_res = '0, mul_res = '0;
    logic [DW-1:0] tree_res = '0, inv_res = '0, sadd_res = '0;
    logic host_we = 1'b0, host_b = 1'b0;
    logic [LL-1:0] host_lane = '0;
    logic [AW-1:0] host_addr = '0, rd_addr = '0;
    logic [DW-1:0] host_data = '0;
    logic [L-1:0] zero_a = '0, zero_b = '0;
    logic [L*DW-1:0] rd_a, rd_b;
    logic [L-1:0] wr_en_a, wr_en_b;
    logic [AW-1:0] wr_addr;
    logic [2:0] wsel;
    logic host_gnt, busy, done, cfg_err;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    mat_bank_sequencer uut (.*);

    always #10 clk = ~clk;

    // entry: layout[15:14] n[13:10] base[9:4] tgt_b[3] src[2:0]
    localparam logic [15:0] VEC [0:5] = '{
        {2'd0, 4'd4, 6'd0,  1'b0, 3'd3},
        {2'd0, 4'd8, 6'd16, 1'b1, 3'd1},
        {2'd1, 4'd4, 6'd8,  1'b0, 3'd2},
        {2'd1, 4'd8, 6'd0,  1'b1, 3'd3},
        {2'd2, 4'd8, 6'd40, 1'b0, 3'd3},
        {2'd0, 4'd4, 6'd62, 1'b0, 3'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_d(input int s, input bit b, input logic [DW-1:0] v, input int k);
        logic [DW-1:0] r;
        case (s)
            1: r = v ^ DW'(16'h0101 * (k + 1));
            2: r = v + DW'(16'h0011 * (k + 1));
            4: r = b ? (v ^ 16'hFF00) : (v ^ 16'h00FF);
            default: r = v;
        endcase
        return r;
    endfunction

    task automatic drive(input logic [DW-1:0] v);
        tree_res = v;
        inv_res  = v ^ 16'h00FF;
        sadd_res = v ^ 16'hFF00;
        for (int k = 0; k < L; k++) begin
            add_res[k*DW +: DW] = v ^ DW'(16'h0101 * (k + 1));
            mul_res[k*DW +: DW] = v + DW'(16'h0011 * (k + 1));
        end
    endtask

    task automatic run_op(input int id, input logic [15:0] ent, input bit host_poke);
        int lay = int'(ent[15:14]);
        int n = int'(ent[13:10]);
        int base = int'(ent[9:4]);
        bit tb = ent[3];
        int s = int'(ent[2:0]);
        int cnt = (lay == 2) ? n : n * n;
        bit seq_ok = 1;
        string tag = (lay == 0) ? "R2" : (lay == 1) ? "R3" : "R4";
        @(negedge clk);
        start = 1; layout = 2'(lay); mat_n = 4'(n); base_addr = AW'(base);
        tgt_b = tb; src = 3'(s);
        for (int e = 0; e < cnt; e++) begin
            @(negedge clk);
            if (e == 0) chk("R6 cleared by accepted start", {31'd0, cfg_err}, 32'd0);
            // R10: scramble configuration and re-strobe start during the run
            start = (e == 1);
            layout = (lay == 0) ? 2'd1 : 2'd0;
            base_addr = AW'(base) ^ 6'h2A;
            tgt_b = ~tb;
            src = (s == 3) ? 3'd1 : 3'd3;
            mat_n = 4'd4;
            if (host_poke && e == 2) begin
                host_we = 1; host_b = 1; host_lane = 2'd3; host_addr = 6'd50; host_data = 16'h2222;
                #1 chk("R7 no grant while busy", {31'd0, host_gnt}, 32'd0);
            end else host_we = 0;
            drive({id[3:0], 8'(e), 4'h5});
            if (busy !== 1'b1 || done !== 1'b0) seq_ok = 0;
        end
        @(negedge clk);
        start = 0; host_we = 0;
        chk("R5 busy held, no early done", {31'd0, seq_ok}, 32'd1);
        chk("R5 done after last write", {30'd0, busy, done}, 32'd3);
        @(negedge clk);
        chk("R5 back to idle", {30'd0, busy, done}, 32'd0);
        for (int e = 0; e < cnt; e++) begin
            logic [DW-1:0] v = {id[3:0], 8'(e), 4'h5};
            if (lay == 2) begin
                rd_addr = AW'(base + e);
                #1;
                for (int k = 0; k < L; k++)
                    chk({tag, " spread copy"}, rd_b[k*DW +: DW], exp_d(s, 1, v, k));
            end else begin
                int r = e / n, c = e % n;
                int t = (lay == 1) ? (c * n + r) : e;
                int k = t % L;
                rd_addr = AW'(base + t / L);
                #1;
                if (tb) chk({tag, "/R8 B placement"}, rd_b[k*DW +: DW], exp_d(s, 1, v, k));
                else    chk({tag, "/R8 A placement"}, rd_a[k*DW +: DW], exp_d(s, 0, v, k));
            end
        end
    endtask

    task automatic bad_start(input logic [3:0] n, input logic [1:0] lay, input logic [2:0] s);
        @(negedge clk);
        start = 1; mat_n = n; layout = lay; src = s; tgt_b = 0; base_addr = '0;
        @(negedge clk);
        start = 0;
        chk("R6 refused start", {30'd0, cfg_err, busy}, 32'd2);
        chk("R6 nothing written", {24'd0, wr_en_a, wr_en_b}, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 reset state", {28'd0, busy, done, cfg_err, host_gnt}, 32'd0);
        chk("R1 no enables", {24'd0, wr_en_a, wr_en_b}, 32'd0);

        // R7: idle host write, later checked for surviving a busy poke
        @(negedge clk);
        host_we = 1; host_b = 1; host_lane = 2'd3; host_addr = 6'd50; host_data = 16'h1111;
        #1 chk("R7 idle grant", {31'd0, host_gnt}, 32'd1);
        @(negedge clk);
        host_b = 0; host_lane = 2'd1; host_addr = 6'd33; host_data = 16'hBEEF;
        @(negedge clk);
        host_we = 0;

        for (int i = 0; i < 6; i++) run_op(i, VEC[i], i == 0);

        rd_addr = 6'd50;
        #1 chk("R7 busy write dropped", {16'd0, rd_b[3*DW +: DW]}, 32'h1111);

        // R9
        rd_addr = 6'd33; zero_a = 4'b0001;
        #1 chk("R9 unmasked port shows data", {16'd0, rd_a[1*DW +: DW]}, 32'hBEEF);
        zero_a = 4'b0010;
        #1 chk("R9 masked port forced zero", {16'd0, rd_a[1*DW +: DW]}, 32'h0);
        rd_addr = 6'd50; zero_b = 4'b1000;
        #1 chk("R9 masked B port", {16'd0, rd_b[3*DW +: DW]}, 32'h0);
        zero_a = '0; zero_b = '0;

        // R6
        bad_start(4'd6, 2'd0, 3'd3);
        bad_start(4'd2, 2'd0, 3'd3);
        bad_start(4'd0, 2'd1, 3'd3);
        bad_start(4'd8, 2'd3, 3'd3);
        bad_start(4'd8, 2'd0, 3'd0);
        bad_start(4'd4, 2'd0, 3'd5);
        run_op(7, {2'd1, 4'd4, 6'd20, 1'b1, 3'd4}, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule